// File: doc/BRIEF.md
# Event Counter Bank with Overflow Freeze

This block keeps four programmable event counters for one link port. Each counter is 48 bits wide and owns a small control register. The control register chooses which of eight event lanes the counter follows, whether the counter runs, and whether an overflow of that counter is reported. Each event lane carries an 8-bit increment in every cycle. A lane that counts flits usually carries 0, 1 or 2, because two flits move per cycle in each direction. The counter adds that increment to its value on every clock edge.

When a counter with reporting switched on carries out of its top bit, the block does three things. It latches a sticky bit for that counter in a bank status register. It sends a one-cycle overflow message toward a global monitoring unit. It stops all four counters. The bank stays stopped until software clears the sticky bit by writing a one to it. A separate freeze input from the global unit can also stop the bank. Software programs and reads the bank through a plain register port. Register writes take effect on the clock edge. Reads are combinational from the address.

Top module: `pmc_bank`

## Requirements
- R1: After reset, all counters read 0. All control registers read 0. The status register (address 8) reads 0. `ovf_msg` is low.
- R2: A counter whose run bit (control bit 8) is set adds the 8-bit value of its selected lane at every clock edge. The result can be read at its address (counter i at address i) one edge later.
- R3: Control bits [2:0] select the lane. Lanes 0–3 carry receive events and lanes 4–7 carry transmit events, so one counter follows exactly one lane, and therefore one direction. Activity on any other lane has no effect on that counter.
- R4: A counter whose run bit is clear holds its value whatever its lane carries.
- R5: On a carry out of bit 47, the counter keeps the low 48 bits of the sum.
- R6: An overflow of a counter whose report bit (control bit 9) is set does two things at the same edge. It sets status bit i, and it raises `ovf_msg` for exactly one cycle. `ovf_msg` is raised only when a status bit goes from 0 to 1.
- R7: While any status bit is set, none of the four counters advances.
- R8: While `freeze_in` is high, none of the four counters advances.
- R9: A status bit clears only when a one is written to its position at address 8. Writing a zero has no effect. After the clear, counting resumes, and a later overflow produces a new pulse.
- R10: An overflow of a counter whose report bit is clear wraps the counter. It sets no status bit, sends no message and stops nothing.
- R11: A write to a counter address loads the written value in place of that cycle's increment.
- R12: Writing control bit 10 together with a control write zeroes that counter at the same edge. Bit 10 always reads back as 0. Control register i lives at address 4+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, taken at the clock edge |
| reg_addr | input | 4 | Register address: counters 0–3, controls 4–7, status 8 |
| reg_wdata | input | 48 | Write data |
| reg_rdata | output | 48 | Combinational read data for `reg_addr` |
| evt_inc | input | 64 | Eight 8-bit lane increments; lane k occupies bits [8k+7:8k] |
| freeze_in | input | 1 | Global freeze; holds all counters while high |
| ovf_msg | output | 1 | One-cycle overflow message toward the global unit |

## Verification
Each result becomes visible at a fixed point after its stimulus:
- A counter value, a control value or a status bit is due one clock edge after the increment or write that causes it. It is read back combinationally in the following low phase.
- `ovf_msg` is registered at the same edge that sets the status bit. It must fall again one edge later.
- A freeze from a status bit starts at the edge after the overflow edge. The overflow cycle itself still counts on every counter.

The bench drives every input on the falling edge. Each lane value is held for a known number of rising edges, so every expected value is a sum the bench can predict. The message pin is sampled at the falling edges directly after and two after the overflow edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  // bit positions inside a control register
  localparam int CTL_EN_BIT  = 8;
  localparam int CTL_OVE_BIT = 9;
  localparam int CTL_RST_BIT = 10;
endpackage

// File: rtl/pmc_event_mux.sv
module pmc_event_mux #(
  parameter int NUM_EVT = 8,
  parameter int INC_W   = 8,
  localparam int SEL_W  = $clog2(NUM_EVT)
) (
  input  logic [NUM_EVT*INC_W-1:0] evt_inc,
  input  logic [SEL_W-1:0]         sel,
  output logic [INC_W-1:0]         inc
);
  logic [INC_W-1:0] lane [NUM_EVT];

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_lane
    assign lane[g] = evt_inc[g*INC_W +: INC_W];
  end

  if (NUM_EVT == (1 << SEL_W)) begin : g_full
    assign inc = lane[sel];
  end else begin : g_part
    assign inc = (int'(sel) < NUM_EVT) ? lane[sel] : '0;
  end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int NUM_EVT = 8,
  parameter int INC_W   = 8,
  parameter int CTR_W   = 48,
  localparam int SEL_W  = $clog2(NUM_EVT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctr_we,
  input  logic                     ctl_we,
  input  logic [CTR_W-1:0]         wval,
  input  logic [SEL_W-1:0]         wsel,
  input  logic                     wen,
  input  logic                     wove,
  input  logic                     wrst,
  input  logic [NUM_EVT*INC_W-1:0] evt_inc,
  input  logic                     count_ok,
  output logic [CTR_W-1:0]         value,
  output logic [SEL_W-1:0]         sel,
  output logic                     en,
  output logic                     ove,
  output logic                     ovf_evt
);
  logic [INC_W-1:0] inc;
  logic [CTR_W:0]   sum;
  logic             adv;
  logic             zero_req;

  pmc_event_mux #(.NUM_EVT(NUM_EVT), .INC_W(INC_W)) u_mux (
    .evt_inc (evt_inc),
    .sel     (sel),
    .inc     (inc)
  );

  assign sum      = {1'b0, value} + {{(CTR_W + 1 - INC_W){1'b0}}, inc};
  assign adv      = en & count_ok;
  assign zero_req = ctl_we & wrst;
  // carry out is reported only when the sum is actually stored
  assign ovf_evt  = adv & sum[CTR_W] & ove & ~ctr_we & ~zero_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
      en  <= 1'b0;
      ove <= 1'b0;
    end else if (ctl_we) begin
      sel <= wsel;
      en  <= wen;
      ove <= wove;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= '0;
    else if (ctr_we)   value <= wval;
    else if (zero_req) value <= '0;
    else if (adv)      value <= sum[CTR_W-1:0];
  end
endmodule

// File: rtl/pmc_status.sv
module pmc_status #(
  parameter int NUM_CTR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] ovf_evt,
  input  logic               clr_we,
  input  logic [NUM_CTR-1:0] clr_mask,
  input  logic               freeze_in,
  output logic [NUM_CTR-1:0] status_q,
  output logic               ovf_msg,
  output logic               count_ok
);
  logic [NUM_CTR-1:0] clr_bits;
  logic [NUM_CTR-1:0] new_set;

  assign clr_bits = clr_we ? clr_mask : '0;
  assign new_set  = ovf_evt & ~status_q;
  assign count_ok = ~freeze_in & ~(|status_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ovf_msg  <= 1'b0;
    end else begin
      // a fresh overflow wins over a clear in the same cycle
      status_q <= (status_q & ~clr_bits) | ovf_evt;
      ovf_msg  <= |new_set;
    end
  end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int INC_W   = 8,
  parameter int NUM_EVT = 8,
  parameter int ADDR_W  = 4,
  localparam int SEL_W   = $clog2(NUM_EVT),
  localparam int STS_ADR = 2 * NUM_CTR
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [CTR_W-1:0]         reg_wdata,
  output logic [CTR_W-1:0]         reg_rdata,
  input  logic [NUM_EVT*INC_W-1:0] evt_inc,
  input  logic                     freeze_in,
  output logic                     ovf_msg
);
  import pmc_pkg::*;

  logic [CTR_W-1:0]       cnt_val [NUM_CTR];
  logic [SEL_W-1:0]       sel_val [NUM_CTR];
  logic [NUM_CTR-1:0]     en_val;
  logic [NUM_CTR-1:0]     ove_val;
  logic [NUM_CTR-1:0]     ovf_evt;
  logic [NUM_CTR-1:0]     ctr_we;
  logic [NUM_CTR-1:0]     ctl_we;
  logic [NUM_CTR-1:0]     status_q;
  logic [NUM_CTR*CTR_W-1:0] ctr_flat;
  logic                   count_ok;
  logic                   sts_we;

  assign sts_we = reg_wr_en && (reg_addr == ADDR_W'(STS_ADR));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign ctr_we[i] = reg_wr_en && (reg_addr == ADDR_W'(i));
    assign ctl_we[i] = reg_wr_en && (reg_addr == ADDR_W'(NUM_CTR + i));
    assign ctr_flat[i*CTR_W +: CTR_W] = cnt_val[i];

    pmc_counter #(
      .NUM_EVT (NUM_EVT),
      .INC_W   (INC_W),
      .CTR_W   (CTR_W)
    ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctr_we   (ctr_we[i]),
      .ctl_we   (ctl_we[i]),
      .wval     (reg_wdata),
      .wsel     (reg_wdata[SEL_W-1:0]),
      .wen      (reg_wdata[CTL_EN_BIT]),
      .wove     (reg_wdata[CTL_OVE_BIT]),
      .wrst     (reg_wdata[CTL_RST_BIT]),
      .evt_inc  (evt_inc),
      .count_ok (count_ok),
      .value    (cnt_val[i]),
      .sel      (sel_val[i]),
      .en       (en_val[i]),
      .ove      (ove_val[i]),
      .ovf_evt  (ovf_evt[i])
    );
  end

  pmc_status #(.NUM_CTR(NUM_CTR)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf_evt   (ovf_evt),
    .clr_we    (sts_we),
    .clr_mask  (reg_wdata[NUM_CTR-1:0]),
    .freeze_in (freeze_in),
    .status_q  (status_q),
    .ovf_msg   (ovf_msg),
    .count_ok  (count_ok)
  );

  always_comb begin
    logic [CTR_W-1:0] view;
    reg_rdata = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      view = '0;
      view[SEL_W-1:0]  = sel_val[i];
      view[CTL_EN_BIT]  = en_val[i];
      view[CTL_OVE_BIT] = ove_val[i];
      if (reg_addr == ADDR_W'(i))           reg_rdata = cnt_val[i];
      if (reg_addr == ADDR_W'(NUM_CTR + i)) reg_rdata = view;
    end
    if (reg_addr == ADDR_W'(STS_ADR)) reg_rdata = CTR_W'(status_q);
  end
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr_en,
  input logic                     freeze_in,
  input logic                     ovf_msg,
  input logic [NUM_CTR-1:0]       status_q,
  input logic [NUM_CTR*CTR_W-1:0] ctr_flat
);
  // R6
  msg_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_msg |=> !ovf_msg);

  // R6
  msg_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_msg |-> (status_q != '0));

  // R6
  new_status_has_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) != '0) |-> ovf_msg);

  // R9
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr_en) |-> ((status_q & $past(status_q)) == $past(status_q)));

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q != '0) && !reg_wr_en) |=> $stable(ctr_flat));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_in && !reg_wr_en) |=> $stable(ctr_flat));
endmodule

bind pmc_bank pmc_bank_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .freeze_in (freeze_in),
  .ovf_msg   (ovf_msg),
  .status_q  (status_q),
  .ctr_flat  (ctr_flat)
);

// File: tb/pmc_bank_bench.sv
module pmc_bank_bench;
  localparam logic [47:0] EN  = 48'h100;
  localparam logic [47:0] OVE = 48'h200;
  localparam logic [47:0] RST = 48'h400;
  localparam logic [47:0] TOP = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [47:0] reg_wdata = '0;
  logic [47:0] reg_rdata;
  logic [63:0] evt_inc = '0;
  logic        freeze_in = 1'b0;
  logic        ovf_msg;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pmc_bank u_pmc_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_inc(evt_inc),
    .freeze_in(freeze_in), .ovf_msg(ovf_msg)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [47:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [47:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic lane(int k, logic [7:0] v);
    evt_inc[k*8 +: 8] = v;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [47:0] d;
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), d);
      check("R1 register reset", d, 48'h0);
    end
    check("R1 message reset", 48'(ovf_msg), 48'h0);
  endtask

  task automatic t_count();
    logic [47:0] d;
    wr(4, EN | 48'd0);
    lane(0, 8'd5); run(4); lane(0, 8'd0);
    rd(0, d); check("R2 steady increment", d, 48'd20);
    @(negedge clk);
    lane(0, 8'd1); run(1); lane(0, 8'd2); run(1);
    lane(0, 8'd0); run(1); lane(0, 8'd2); run(1); lane(0, 8'd0);
    rd(0, d); check("R2 varying increment", d, 48'd25);
  endtask

  task automatic t_select();
    logic [47:0] d;
    wr(5, EN | 48'd6);
    @(negedge clk);
    lane(2, 8'd4); lane(6, 8'd9); run(1); lane(2, 8'd0); lane(6, 8'd0);
    rd(1, d); check("R3 tx lane selected", d, 48'd9);
    rd(0, d); check("R3 other counter untouched", d, 48'd25);
    rd(5, d); check("R3 control readback", d, EN | 48'd6);
  endtask

  task automatic t_disable();
    logic [47:0] d;
    wr(6, 48'd3);
    lane(3, 8'd7); run(3); lane(3, 8'd0);
    rd(2, d); check("R4 disabled holds", d, 48'd0);
  endtask

  task automatic t_write();
    logic [47:0] d;
    wr(7, EN | 48'd7);
    lane(7, 8'd7);
    wr(3, 48'd100);
    lane(7, 8'd0);
    rd(3, d); check("R11 write replaces increment", d, 48'd100);
  endtask

  task automatic t_rst_bit();
    logic [47:0] d;
    wr(4, RST | EN | 48'd0);
    rd(0, d); check("R12 reset bit zeroes counter", d, 48'd0);
    rd(4, d); check("R12 reset bit reads 0", d, EN);
  endtask

  task automatic t_freeze();
    logic [47:0] d;
    @(negedge clk);
    freeze_in = 1'b1; lane(0, 8'd3); run(3);
    freeze_in = 1'b0; lane(0, 8'd0);
    rd(0, d); check("R8 frozen holds", d, 48'd0);
    @(negedge clk);
    lane(0, 8'd3); run(2); lane(0, 8'd0);
    rd(0, d); check("R8 counting after release", d, 48'd6);
  endtask

  task automatic t_wrap_quiet();
    logic [47:0] d;
    wr(2, TOP - 48'd1);
    wr(6, EN | 48'd3);
    lane(3, 8'd5); run(1); lane(3, 8'd0);
    check("R10 no message", 48'(ovf_msg), 48'h0);
    rd(2, d); check("R10 wraps", d, 48'd3);
    rd(8, d); check("R10 no status", d, 48'd0);
    @(negedge clk);
    lane(3, 8'd1); run(1); lane(3, 8'd0);
    rd(2, d); check("R10 not frozen", d, 48'd4);
  endtask

  task automatic t_overflow();
    logic [47:0] d;
    wr(0, 48'd0);
    wr(1, TOP - 48'd2);
    wr(5, EN | OVE | 48'd6);
    @(negedge clk);
    lane(6, 8'd5); lane(0, 8'd2); lane(3, 8'd1);
    run(1);
    check("R6 message raised", 48'(ovf_msg), 48'h1);
    run(1);
    check("R6 message one cycle", 48'(ovf_msg), 48'h0);
    run(2);
    lane(6, 8'd0); lane(0, 8'd0); lane(3, 8'd0);
    rd(1, d); check("R5 wrapped value", d, 48'd2);
    rd(0, d); check("R7 bank held after overflow", d, 48'd2);
    rd(2, d); check("R7 other counter held", d, 48'd5);
    rd(8, d); check("R6 status bit 1", d, 48'd2);
  endtask

  task automatic t_clear();
    logic [47:0] d;
    wr(8, 48'd0);
    rd(8, d); check("R9 zero write keeps status", d, 48'd2);
    wr(8, 48'd2);
    rd(8, d); check("R9 one write clears", d, 48'd0);
    @(negedge clk);
    lane(6, 8'd1); run(1); lane(6, 8'd0);
    rd(1, d); check("R9 counting resumes", d, 48'd3);
    wr(1, TOP);
    lane(6, 8'd1); run(1); lane(6, 8'd0);
    check("R9 second message", 48'(ovf_msg), 48'h1);
    rd(8, d); check("R9 status set again", d, 48'd2);
    wr(8, 48'd2);
  endtask

  initial begin
    #100000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_select();
    t_disable();
    t_write();
    t_rst_bit();
    t_freeze();
    t_wrap_quiet();
    t_overflow();
    t_clear();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule